// File: doc/BRIEF.md
# Programmable Memory Channel Sequencer

This block is a banked on-chip memory. Each channel owns one word array and streams from it under control of a small set of 32-bit configuration instructions. Channels are bundled into address groups. An address instruction gives a group a base made of a start address plus an offset. A channel instruction arms one channel as a writer (input mode) or a reader (output mode), with a word count and an optional wrap-around. A single start instruction, with a programmable delay, releases every enabled reader at once. This lets a compute stage begin only after its input buffering has finished.

A writer stores each accepted word at the next sequential address, starting from its group base. A reader presents words from base to base+count-1 in order on a valid/ready stream. Back-pressure rules for the reader: a word moves only on a cycle where both valid and ready are high. While ready is low, valid and the data word stay unchanged. Valid never waits for ready. A writer's ready depends only on its configuration, never on its valid. Configuration, done and the start instruction use plain pins.

Top module: `mem_chan_seq`

## Requirements
- R1: After reset every channel is disabled: `wr_ready`, `rd_valid` and `done` are all low.
- R2: An address instruction (bits 31:30 = 01) sets the base of group bits 29:28 to start (bits 15:8) plus offset (bits 7:0), modulo the depth. Channel c belongs to group c / CH_PER_GRP. A reader copies its group base when it is launched, and a writer copies it when it is configured.
- R3: A channel instruction (bits 31:30 = 10) targets channel bits 29:27 and sets enable (bit 26), direction (bit 25, 1 = output), loop (bit 24) and count (bits 8:0). It stops the channel at once, clearing `rd_valid` and `done`.
- R4: An enabled input channel holds `wr_ready` high. Its k-th accepted word, counting from 0 since the channel was configured, is stored at base+k modulo the depth.
- R5: A start instruction (bits 31:30 = 11) carries a delay D in bits 15:0. Every enabled output channel raises `rd_valid` exactly D+1 clock edges after the edge that accepts the start.
- R6: A launched reader delivers the words at base, base+1, ..., base+count-1 (modulo the depth) in order, one per valid/ready transfer. During a stall it holds valid and data stable.
- R7: Without loop, the count-th transfer ends the stream. `rd_valid` then falls and `done` rises and stays high until the next channel or start instruction.
- R8: With loop, the transfer after base+count-1 returns to base, and streaming continues until the channel is reconfigured.
- R9: An input channel ignores the start instruction: it raises neither `rd_valid` nor `done`, and it keeps accepting writes.
- R10: An output channel programmed with count 0 goes straight to `done` on launch, without presenting any word.
- R11: A disabled channel ignores the start instruction and keeps `wr_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Configuration word present this cycle |
| cfg_word | input | 32 | Configuration instruction |
| wr_valid | input | NCH | Per-channel write word valid |
| wr_data | input | NCH*32 | Per-channel write words, channel c in bits c*32 +: 32 |
| wr_ready | output | NCH | Per-channel write acceptance |
| rd_valid | output | NCH | Per-channel read word valid |
| rd_data | output | NCH*32 | Per-channel read words, channel c in bits c*32 +: 32 |
| rd_ready | input | NCH | Per-channel read acceptance |
| done | output | NCH | Per-channel finished flag for non-looping reads |

## Verification
An error in the delay counter shows up at the ports on the very first launch, as a first valid that arrives one cycle early or late. A wrong base or read pointer appears as a wrong word at the first misplaced transfer. The wrap test places a base three words below the top of the array, so a pointer that fails to wrap modulo the depth also fails there. An error in the count comparison stays hidden until the count boundary. It then appears either as an extra or missing word and a late or early `done`, or, for looping channels, as a word that is not the expected base word after the wrap.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 9;
  localparam int DLY_W  = 16;
  localparam int AFLD_W = 8;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_ADDR  = 2'b01,
    OP_CHAN  = 2'b10,
    OP_START = 2'b11
  } op_e;

  typedef struct packed {
    logic             en;
    logic             out;
    logic             loop;
    logic [CNT_W-1:0] cnt;
  } chan_cfg_t;
endpackage

// File: rtl/mcs_decode.sv
module mcs_decode
  import mcs_pkg::*;
#(
  parameter int NGRP = 4,
  parameter int NCH  = 8,
  parameter int AW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_valid,
  input  logic [WORD_W-1:0]    cfg_word,
  output logic [NGRP*AW-1:0]   base_flat,
  output logic [NCH-1:0]       chan_we,
  output chan_cfg_t            chan_cfg,
  output logic                 start_we,
  output logic [DLY_W-1:0]     start_dly
);
  op_e             op;
  logic [1:0]      grp_sel;
  logic [2:0]      ch_sel;
  logic [AW-1:0]   sum;
  logic [AW-1:0]   base_q [NGRP];

  assign op      = op_e'(cfg_word[31:30]);
  assign grp_sel = cfg_word[29:28];
  assign ch_sel  = cfg_word[29:27];
  assign sum     = AW'(cfg_word[15:8]) + AW'(cfg_word[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGRP; g++) base_q[g] <= '0;
    end else if (cfg_valid && op == OP_ADDR) begin
      for (int g = 0; g < NGRP; g++)
        if (grp_sel == 2'(g)) base_q[g] <= sum;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_base
    assign base_flat[g*AW +: AW] = base_q[g];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign chan_we[c] = cfg_valid && (op == OP_CHAN) && (ch_sel == 3'(c));
  end

  assign chan_cfg.en   = cfg_word[26];
  assign chan_cfg.out  = cfg_word[25];
  assign chan_cfg.loop = cfg_word[24];
  assign chan_cfg.cnt  = cfg_word[CNT_W-1:0];

  assign start_we  = cfg_valid && (op == OP_START);
  assign start_dly = cfg_word[DLY_W-1:0];
endmodule

// File: rtl/mcs_launch.sv
module mcs_launch
  import mcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_we,
  input  logic [DLY_W-1:0] start_dly,
  output logic             go
);
  logic             armed;
  logic [DLY_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      remain <= '0;
    end else if (start_we) begin
      armed  <= 1'b1;
      remain <= start_dly;
    end else if (armed) begin
      if (remain == '0) armed <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assign go = armed && (remain == '0);

  p_go_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go && !start_we |=> !go);
  p_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_we |=> armed);
endmodule

// File: rtl/mcs_channel.sv
module mcs_channel
  import mcs_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  chan_cfg_t         cfg,
  input  logic [AW-1:0]     base,
  input  logic              go,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  input  logic              rd_ready,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_e;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  st_e              state;
  chan_cfg_t        cfg_q;
  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] ptr;
  logic [AW-1:0]    wptr;
  logic [AW-1:0]    rd_addr;
  logic [WORD_W-1:0] mem [DEPTH];

  assign wr_ready = cfg_q.en && !cfg_q.out;
  assign rd_valid = (state == S_RUN);
  assign done     = (state == S_DONE);
  assign rd_addr  = base_q + AW'(ptr);
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_valid && wr_ready) mem[base_q + wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cfg_q  <= '0;
      base_q <= '0;
      ptr    <= '0;
      wptr   <= '0;
    end else if (cfg_we) begin
      cfg_q  <= cfg;
      base_q <= base;
      state  <= S_IDLE;
      ptr    <= '0;
      wptr   <= '0;
    end else begin
      if (wr_valid && wr_ready) wptr <= wptr + 1'b1;
      if (go && cfg_q.en && cfg_q.out) begin
        base_q <= base;
        ptr    <= '0;
        state  <= (cfg_q.cnt == '0) ? S_DONE : S_RUN;
      end else if (state == S_RUN && rd_ready) begin
        if ((ptr + ONE) == cfg_q.cnt) begin
          ptr <= '0;
          if (!cfg_q.loop) state <= S_DONE;
        end else begin
          ptr <= ptr + ONE;
        end
      end
    end
  end

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !cfg_we && !go |=> rd_valid && $stable(rd_data));
  p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ptr < cfg_q.cnt);
  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rd_valid) || $past(go));
  p_loop_alive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && cfg_q.loop && !cfg_we && !go |=> rd_valid);
  p_in_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !rd_valid && !done);
endmodule

// File: rtl/mem_chan_seq.sv
module mem_chan_seq
  import mcs_pkg::*;
#(
  parameter int NGRP       = 4,
  parameter int CH_PER_GRP = 2,
  parameter int DEPTH      = 256,
  localparam int NCH       = NGRP * CH_PER_GRP,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_valid,
  input  logic [31:0]           cfg_word,
  input  logic [NCH-1:0]        wr_valid,
  input  logic [NCH*32-1:0]     wr_data,
  output logic [NCH-1:0]        wr_ready,
  output logic [NCH-1:0]        rd_valid,
  output logic [NCH*32-1:0]     rd_data,
  input  logic [NCH-1:0]        rd_ready,
  output logic [NCH-1:0]        done
);
  logic [NGRP*AW-1:0] base_flat;
  logic [NCH-1:0]     chan_we;
  chan_cfg_t          chan_cfg;
  logic               start_we;
  logic [DLY_W-1:0]   start_dly;
  logic               go;

  mcs_decode #(.NGRP(NGRP), .NCH(NCH), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .base_flat(base_flat), .chan_we(chan_we), .chan_cfg(chan_cfg),
    .start_we(start_we), .start_dly(start_dly)
  );

  mcs_launch u_launch (
    .clk(clk), .rst_n(rst_n), .start_we(start_we), .start_dly(start_dly), .go(go)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int GRP = c / CH_PER_GRP;
    mcs_channel #(.DEPTH(DEPTH), .AW(AW)) u_ch (
      .clk(clk), .rst_n(rst_n), .cfg_we(chan_we[c]), .cfg(chan_cfg),
      .base(base_flat[GRP*AW +: AW]), .go(go),
      .wr_valid(wr_valid[c]), .wr_data(wr_data[c*WORD_W +: WORD_W]),
      .wr_ready(wr_ready[c]), .rd_valid(rd_valid[c]),
      .rd_data(rd_data[c*WORD_W +: WORD_W]), .rd_ready(rd_ready[c]),
      .done(done[c])
    );
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_valid == '0 && done == '0);
endmodule

// File: tb/test_mem_chan_seq.sv
module test_mem_chan_seq;
  localparam int NCH = 8;

  typedef struct packed {
    logic [2:0]  ch;
    logic [7:0]  st;
    logic [7:0]  of;
    logic [8:0]  cnt;
    logic        lp;
    logic [15:0] dly;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{3'd0, 8'd10,  8'd2,  9'd5, 1'b0, 16'd0},
    '{3'd3, 8'd250, 8'd3,  9'd6, 1'b1, 16'd4},
    '{3'd5, 8'd0,   8'd0,  9'd1, 1'b0, 16'd7},
    '{3'd6, 8'd100, 8'd50, 9'd4, 1'b1, 16'd1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_valid = 1'b0;
  logic [31:0]       cfg_word = '0;
  logic [NCH-1:0]    wr_valid = '0;
  logic [NCH*32-1:0] wr_data = '0;
  logic [NCH-1:0]    wr_ready;
  logic [NCH-1:0]    rd_valid;
  logic [NCH*32-1:0] rd_data;
  logic [NCH-1:0]    rd_ready = '0;
  logic [NCH-1:0]    done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mem_chan_seq i_mem_chan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .done(done)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    cfg_valid = 1'b1;
    cfg_word  = w;
    step();
    cfg_valid = 1'b0;
    cfg_word  = '0;
  endtask

  task automatic addr_ins(input int g, input logic [7:0] s, input logic [7:0] o);
    send({2'b01, 2'(g), 12'b0, s, o});
  endtask

  task automatic chan_ins(input int ch, input bit en, input bit out, input bit lp, input logic [8:0] cnt);
    send({2'b10, 3'(ch), en, out, lp, 15'b0, cnt});
  endtask

  task automatic start_ins(input logic [15:0] d);
    send({2'b11, 14'b0, d});
  endtask

  function automatic logic [31:0] pat(input int ch, input int k);
    return 32'hA000_0000 | (32'(ch) << 16) | 32'(k);
  endfunction

  function automatic logic [31:0] lane(input int ch);
    return rd_data[ch*32 +: 32];
  endfunction

  task automatic wait_valid(input int ch, output int n);
    n = 0;
    while (!rd_valid[ch] && n < 300) begin
      step();
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] held;
    repeat (3) step();
    chk(rd_valid == '0 && done == '0 && wr_ready == '0, "R1 in reset", {8'b0, rd_valid, done, wr_ready}, 32'h0);
    rst_n = 1'b1;
    step();
    chk(rd_valid == '0 && done == '0 && wr_ready == '0, "R1 after reset", {8'b0, rd_valid, done, wr_ready}, 32'h0);

    for (int v = 0; v < 4; v++) begin
      automatic int ch  = int'(VECS[v].ch);
      automatic int cnt = int'(VECS[v].cnt);
      automatic int tot = VECS[v].lp ? cnt + 3 : cnt;
      addr_ins(ch / 2, VECS[v].st, VECS[v].of);
      chan_ins(ch, 1'b1, 1'b0, 1'b0, 9'd0);
      for (int k = 0; k < cnt; k++) begin
        chk(wr_ready[ch], "R4 writer ready", 32'(wr_ready[ch]), 32'h1);
        wr_valid[ch] = 1'b1;
        wr_data[ch*32 +: 32] = pat(ch, k);
        step();
      end
      wr_valid[ch] = 1'b0;
      chan_ins(ch, 1'b1, 1'b1, VECS[v].lp, VECS[v].cnt);
      rd_ready[ch] = 1'b1;
      start_ins(VECS[v].dly);
      wait_valid(ch, n);
      chk(n == int'(VECS[v].dly) + 1, "R5 start delay", 32'(n), 32'(VECS[v].dly) + 1);
      for (int k = 0; k < tot; k++) begin
        chk(rd_valid[ch], "R6 valid during stream", 32'(rd_valid[ch]), 32'h1);
        chk(lane(ch) == pat(ch, k % cnt), (k >= cnt) ? "R8 wrapped word" : "R6 word order",
            lane(ch), pat(ch, k % cnt));
        if (k == 1) begin
          held = lane(ch);
          rd_ready[ch] = 1'b0;
          step();
          chk(rd_valid[ch] && lane(ch) == held, "R6 stall hold", lane(ch), held);
          rd_ready[ch] = 1'b1;
        end
        step();
      end
      if (!VECS[v].lp) begin
        chk(!rd_valid[ch] && done[ch], "R7 end of count", {30'b0, rd_valid[ch], done[ch]}, 32'h1);
        step();
        chk(done[ch], "R7 done persists", 32'(done[ch]), 32'h1);
      end else begin
        chk(rd_valid[ch], "R8 loop keeps streaming", 32'(rd_valid[ch]), 32'h1);
      end
      rd_ready[ch] = 1'b0;
      chan_ins(ch, 1'b0, 1'b0, 1'b0, 9'd0);
      chk(!rd_valid[ch] && !done[ch], "R3 reconfig stops", {30'b0, rd_valid[ch], done[ch]}, 32'h0);
    end

    // R2: channel 0 wrote words 0..4 at 12..16; a base of 11+3=14 must yield words 2 and 3
    addr_ins(0, 8'd11, 8'd3);
    chan_ins(0, 1'b1, 1'b1, 1'b0, 9'd2);
    rd_ready[0] = 1'b1;
    start_ins(16'd0);
    wait_valid(0, n);
    chk(n == 1, "R5 zero delay", 32'(n), 32'h1);
    chk(lane(0) == pat(0, 2), "R2 base first word", lane(0), pat(0, 2));
    step();
    chk(lane(0) == pat(0, 3), "R2 base second word", lane(0), pat(0, 3));
    step();
    chk(done[0] && !rd_valid[0], "R7 short count", {30'b0, rd_valid[0], done[0]}, 32'h1);
    rd_ready[0] = 1'b0;
    chan_ins(0, 1'b0, 1'b0, 1'b0, 9'd0);

    // R9: input channel ignores the start flag
    chan_ins(1, 1'b1, 1'b0, 1'b0, 9'd4);
    start_ins(16'd0);
    repeat (3) step();
    chk(!rd_valid[1] && !done[1], "R9 input ignores start", {30'b0, rd_valid[1], done[1]}, 32'h0);
    chk(wr_ready[1], "R9 input still accepts", 32'(wr_ready[1]), 32'h1);
    chan_ins(1, 1'b0, 1'b0, 1'b0, 9'd0);

    // R11: disabled channel ignores start
    start_ins(16'd0);
    repeat (3) step();
    chk(!rd_valid[2] && !done[2] && !wr_ready[2], "R11 disabled quiet",
        {29'b0, rd_valid[2], done[2], wr_ready[2]}, 32'h0);

    // R10: zero count goes straight to done
    chan_ins(4, 1'b1, 1'b1, 1'b0, 9'd0);
    start_ins(16'd2);
    step();
    step();
    chk(!done[4], "R10 not before launch", 32'(done[4]), 32'h0);
    step();
    chk(done[4] && !rd_valid[4], "R10 zero count done", {30'b0, rd_valid[4], done[4]}, 32'h1);
    chan_ins(4, 1'b1, 1'b1, 1'b0, 9'd0);
    chk(!done[4], "R3 reconfig clears done", 32'(done[4]), 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule